// File: doc/BRIEF.md
# Locked Command Mailbox Controller

This block is a register-mapped mailbox through which a requester hands a command, a byte length and a payload to a secure responder. The requester first claims the mailbox by reading the claim register. That read returns 0 when the claim succeeds. The requester then writes the command word, then the length, then the payload words, and finally sets the run flag. The responder takes the queued words from a pop port and reports success or failure. The requester sees that outcome in the status register, then clears the run flag, which ends the transaction and gives up the claim.

A single sequencer state machine enforces the order and reports its state in the status register. It has seven states: `MB_IDLE` (0, unclaimed), `MB_WAIT_CMD` (1), `MB_WAIT_LEN` (2), `MB_WAIT_DATA` (3), `MB_RUN_RSP` (4, responder working), `MB_RUN_REQ` (5, result waiting for the requester) and `MB_FAULT` (6).

Its transitions are:
- claim read: `MB_IDLE` to `MB_WAIT_CMD`
- command write: `MB_WAIT_CMD` to `MB_WAIT_LEN`
- length write: `MB_WAIT_LEN` to `MB_WAIT_DATA`
- run-flag write of 1: `MB_WAIT_DATA` to `MB_RUN_RSP`
- responder done: `MB_RUN_RSP` to `MB_RUN_REQ`
- run-flag write of 0: `MB_RUN_REQ` or `MB_FAULT` to `MB_IDLE`
- any command, length or payload write in the wrong state (claim held): to `MB_FAULT`
- a force-release write: any state to `MB_IDLE`

A typical use is a signature check. It uses command 0x53494756 and a length of 196 bytes: a checksum word (zero minus the byte sum of the command and the payload, mod 2^32) followed by four 48-byte operands.

Top module: `mbx_ctrl`

## Requirements
- R1: A read of byte offset 0x00 while unclaimed returns 0, claims the mailbox and moves the state field to 1.
- R2: While the mailbox is claimed, reads of offset 0x00 return 1 and change nothing.
- R3: Status at offset 0x1C reads as follows. Bit 9 is 1 while the mailbox is claimed. Bits [8:6] hold the sequencer state code listed above. Bits [3:0] hold the command result: 0 busy, 2 complete, 3 failure. Code 1 is never produced. All other bits are 0.
- R4: The states advance in this order. A command write (0x08) moves state 1 to 2. A length write (0x0C) moves 2 to 3. A write of 1 to the run flag (0x18, bit 0) moves 3 to 4 with result busy. In state 4, `rsp_cmd` and `rsp_len` carry the written command and length.
- R5: A command, length or payload (0x10) write while claimed and not in its own state moves the state to 6. A run-flag write of 0 in state 6 returns to state 0 and drops the claim.
- R6: Payload writes beyond ceil(length/4) words are dropped. The responder port presents exactly ceil(length/4) words, in write order, and only in state 4.
- R7: `rsp_done` in state 4 moves the state to 5, with result 3 if `rsp_fail` is set and 2 otherwise. `rsp_result` is latched and is readable at offset 0x14.
- R8: A run-flag write of 0 in state 5 returns to state 0: status reads 0, the claim is released and no queued word remains.
- R9: While unclaimed, writes to any offset are ignored. Status stays 0, offset 0x08 reads 0, and a later transaction sees no stale payload.
- R10: A write with bit 0 set to offset 0x20 forces state 0 from any state and releases the claim.
- R11: Offset 0x04 reads the `USER_ID` parameter while claimed and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_addr | input | ADDR_W | Requester byte offset |
| req_wr | input | 1 | Requester write strobe |
| req_rd | input | 1 | Requester read strobe (side effect on claim register) |
| req_wdata | input | 32 | Requester write data |
| req_rdata | output | 32 | Requester read data, combinational from address |
| rsp_valid | output | 1 | Queued word available to responder |
| rsp_pop | input | 1 | Responder takes the head word |
| rsp_word | output | 32 | Head queued word |
| rsp_cmd | output | 32 | Latched command word |
| rsp_len | output | LEN_W | Latched byte length |
| rsp_done | input | 1 | Responder finished (used in state 4 only) |
| rsp_fail | input | 1 | Responder outcome is failure |
| rsp_result | input | 32 | Responder result word latched on done |

## Verification
A sequencer stuck in a wrong state shows up in status bits [8:6] on the very next read, one cycle after the offending write. A lost or leaked claim shows up in the claim register and in bit 9 within one cycle. A payload counter that is off by one appears as a missing or extra word on the responder port during the drain that follows. It also leaves stale words behind, which the next transaction delivers first. The bench sweeps every byte length from 1 to 24, every out-of-order write in each setup state, and a full 196-byte signature transaction with a computed checksum.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [2:0] {
        MB_IDLE      = 3'd0,
        MB_WAIT_CMD  = 3'd1,
        MB_WAIT_LEN  = 3'd2,
        MB_WAIT_DATA = 3'd3,
        MB_RUN_RSP   = 3'd4,
        MB_RUN_REQ   = 3'd5,
        MB_FAULT     = 3'd6
    } mb_state_e;

    typedef enum logic [3:0] {
        CS_BUSY = 4'd0,
        CS_DONE = 4'd2,
        CS_FAIL = 4'd3
    } mb_cstat_e;

    localparam logic [5:0] OFF_CLAIM  = 6'h00;
    localparam logic [5:0] OFF_USER   = 6'h04;
    localparam logic [5:0] OFF_CMD    = 6'h08;
    localparam logic [5:0] OFF_LEN    = 6'h0C;
    localparam logic [5:0] OFF_DIN    = 6'h10;
    localparam logic [5:0] OFF_DOUT   = 6'h14;
    localparam logic [5:0] OFF_RUN    = 6'h18;
    localparam logic [5:0] OFF_STATUS = 6'h1C;
    localparam logic [5:0] OFF_FREE   = 6'h20;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [PW:0]   cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == (PW+1)'(DEPTH));
    assign dout  = mem[rptr];

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else if (flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) wptr <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == PW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
    import mbx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      claim_rd,
    input  logic      cmd_wr,
    input  logic      len_wr,
    input  logic      data_wr,
    input  logic      go_wr,
    input  logic      stop_wr,
    input  logic      free_wr,
    input  logic      rsp_done,
    input  logic      rsp_fail,
    output mb_state_e state,
    output logic [3:0] cstat,
    output logic      flush
);
    mb_state_e nxt;
    mb_cstat_e cs_q;
    logic      misplaced;

    always_comb begin
        nxt = state;
        misplaced = 1'b0;
        if (free_wr) begin
            nxt = MB_IDLE;
        end else begin
            unique case (state)
                MB_IDLE:      if (claim_rd) nxt = MB_WAIT_CMD;
                MB_WAIT_CMD: begin
                    misplaced = len_wr || data_wr;
                    if (cmd_wr) nxt = MB_WAIT_LEN;
                    else if (misplaced) nxt = MB_FAULT;
                end
                MB_WAIT_LEN: begin
                    misplaced = cmd_wr || data_wr;
                    if (len_wr) nxt = MB_WAIT_DATA;
                    else if (misplaced) nxt = MB_FAULT;
                end
                MB_WAIT_DATA: begin
                    misplaced = cmd_wr || len_wr;
                    if (misplaced) nxt = MB_FAULT;
                    else if (go_wr) nxt = MB_RUN_RSP;
                end
                MB_RUN_RSP: begin
                    misplaced = cmd_wr || len_wr || data_wr;
                    if (misplaced) nxt = MB_FAULT;
                    else if (rsp_done) nxt = MB_RUN_REQ;
                end
                MB_RUN_REQ: begin
                    misplaced = cmd_wr || len_wr || data_wr;
                    if (misplaced) nxt = MB_FAULT;
                    else if (stop_wr) nxt = MB_IDLE;
                end
                MB_FAULT:     if (stop_wr) nxt = MB_IDLE;
                default:      nxt = MB_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MB_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cs_q <= CS_BUSY;
        else if (state == MB_RUN_RSP && nxt == MB_RUN_REQ)
            cs_q <= rsp_fail ? CS_FAIL : CS_DONE;
        else if (nxt == MB_IDLE || nxt == MB_RUN_RSP)
            cs_q <= CS_BUSY;
    end

    assign cstat = cs_q;
    assign flush = (nxt == MB_IDLE);

    assert_claim_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MB_IDLE && claim_rd && !free_wr) |=> state == MB_WAIT_CMD);
    assert_order_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MB_WAIT_CMD && (len_wr || data_wr) && !free_wr) |=> state == MB_FAULT);
    assert_result_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MB_RUN_RSP && rsp_done && !(cmd_wr || len_wr || data_wr) && !free_wr)
        |=> (state == MB_RUN_REQ && cstat == ($past(rsp_fail) ? 4'd3 : 4'd2)));
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == MB_RUN_REQ || state == MB_FAULT) && stop_wr && !misplaced) |=> state == MB_IDLE);
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MB_IDLE && !claim_rd) |=> state == MB_IDLE);
    assert_force_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        free_wr |=> state == MB_IDLE);
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int          ADDR_W  = 6,
    parameter int          DEPTH   = 64,
    parameter int          LEN_W   = 16,
    parameter logic [31:0] USER_ID = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    input  logic              req_rd,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       req_rdata,
    output logic              rsp_valid,
    input  logic              rsp_pop,
    output logic [31:0]       rsp_word,
    output logic [31:0]       rsp_cmd,
    output logic [LEN_W-1:0]  rsp_len,
    input  logic              rsp_done,
    input  logic              rsp_fail,
    input  logic [31:0]       rsp_result
);
    localparam int NW = LEN_W + 1;

    mb_state_e     state;
    logic [3:0]    cstat;
    logic          flush, empty, full, push, pop, held;
    logic [31:0]   cmd_q, len_q, res_q;
    logic [NW-1:0] need, pcnt;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [5:0] off);
        return a == ADDR_W'(off);
    endfunction

    logic claim_rd, cmd_wr, len_wr, data_wr, go_wr, stop_wr, free_wr, done_ok;
    assign claim_rd = req_rd && hit(req_addr, OFF_CLAIM);
    assign cmd_wr   = req_wr && hit(req_addr, OFF_CMD);
    assign len_wr   = req_wr && hit(req_addr, OFF_LEN);
    assign data_wr  = req_wr && hit(req_addr, OFF_DIN);
    assign go_wr    = req_wr && hit(req_addr, OFF_RUN) && req_wdata[0];
    assign stop_wr  = req_wr && hit(req_addr, OFF_RUN) && !req_wdata[0];
    assign free_wr  = req_wr && hit(req_addr, OFF_FREE) && req_wdata[0];
    assign done_ok  = rsp_done && (state == MB_RUN_RSP);

    mbx_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .claim_rd(claim_rd), .cmd_wr(cmd_wr), .len_wr(len_wr), .data_wr(data_wr),
        .go_wr(go_wr), .stop_wr(stop_wr), .free_wr(free_wr),
        .rsp_done(done_ok), .rsp_fail(rsp_fail),
        .state(state), .cstat(cstat), .flush(flush)
    );

    assign held = (state != MB_IDLE);
    assign need = ({1'b0, len_q[LEN_W-1:0]} + NW'(3)) >> 2;
    assign push = data_wr && (state == MB_WAIT_DATA) && !free_wr && (pcnt < need) && !full;
    assign pop  = rsp_pop && rsp_valid;

    mbx_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(push), .din(req_wdata), .pop(pop),
        .dout(rsp_word), .empty(empty), .full(full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            len_q <= '0;
            res_q <= '0;
            pcnt  <= '0;
        end else if (flush) begin
            cmd_q <= '0;
            len_q <= '0;
            res_q <= '0;
            pcnt  <= '0;
        end else begin
            if (cmd_wr && state == MB_WAIT_CMD) cmd_q <= req_wdata;
            if (len_wr && state == MB_WAIT_LEN) len_q <= req_wdata;
            if (push) pcnt <= pcnt + 1'b1;
            if (done_ok) res_q <= rsp_result;
        end
    end

    assign rsp_valid = (state == MB_RUN_RSP) && !empty;
    assign rsp_cmd   = cmd_q;
    assign rsp_len   = len_q[LEN_W-1:0];

    always_comb begin
        req_rdata = '0;
        if (hit(req_addr, OFF_CLAIM))       req_rdata = {31'b0, held};
        else if (hit(req_addr, OFF_USER))   req_rdata = held ? USER_ID : '0;
        else if (hit(req_addr, OFF_CMD))    req_rdata = cmd_q;
        else if (hit(req_addr, OFF_LEN))    req_rdata = len_q;
        else if (hit(req_addr, OFF_DOUT))   req_rdata = res_q;
        else if (hit(req_addr, OFF_RUN))
            req_rdata = {31'b0, state == MB_RUN_RSP || state == MB_RUN_REQ};
        else if (hit(req_addr, OFF_STATUS))
            req_rdata = {22'b0, held, state, 2'b00, cstat};
    end

    assert_push_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MB_WAIT_DATA) |-> pcnt <= need);
    assert_pop_only_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> state == MB_RUN_RSP);
    assert_idle_no_words_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MB_IDLE) |-> !rsp_valid);
endmodule

// File: tb/test_mbx_ctrl.sv
module test_mbx_ctrl;
    localparam int LEN_W = 16;
    localparam logic [31:0] UID = 32'h0000_00A5;

    logic        clk = 0, rst_n = 0;
    logic [5:0]  req_addr = '0;
    logic        req_wr = 0, req_rd = 0;
    logic [31:0] req_wdata = '0, req_rdata;
    logic        rsp_valid, rsp_pop = 0, rsp_done = 0, rsp_fail = 0;
    logic [31:0] rsp_word, rsp_cmd, rsp_result = '0;
    logic [LEN_W-1:0] rsp_len;

    int n_chk = 0, n_bad = 0;
    logic [31:0] exp_w [64];

    always #2 clk = ~clk;

    mbx_ctrl #(.ADDR_W(6), .DEPTH(64), .LEN_W(LEN_W), .USER_ID(UID)) i_mbx_ctrl (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wr(req_wr), .req_rd(req_rd),
        .req_wdata(req_wdata), .req_rdata(req_rdata), .rsp_valid(rsp_valid),
        .rsp_pop(rsp_pop), .rsp_word(rsp_word), .rsp_cmd(rsp_cmd), .rsp_len(rsp_len),
        .rsp_done(rsp_done), .rsp_fail(rsp_fail), .rsp_result(rsp_result));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        req_addr = a; req_wdata = d; req_wr = 1;
        @(posedge clk); #1 req_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        req_addr = a; req_rd = 1;
        #1 v = req_rdata;
        @(posedge clk); #1 req_rd = 0;
    endtask

    function automatic logic [31:0] st(input int held, input int s, input int cs);
        return (32'(held) << 9) | (32'(s) << 6) | 32'(cs);
    endfunction

    task automatic drain(input string tag, input int expn);
        int got = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (rsp_valid) begin
                if (got < 64) chk(tag, rsp_word, exp_w[got]);
                got++;
                rsp_pop = 1;
            end else begin
                rsp_pop = 0;
                if (k > 0) break;
            end
        end
        rsp_pop = 0;
        chk(tag, 32'(got), 32'(expn));
    endtask

    task automatic respond(input logic f, input logic [31:0] r);
        @(negedge clk);
        rsp_done = 1; rsp_fail = f; rsp_result = r;
        @(posedge clk); #1 rsp_done = 0;
    endtask

    task automatic run_txn(input logic [31:0] cmd, input int len, input int extra,
                           input logic f, input logic [31:0] res);
        logic [31:0] v;
        int need = (len + 3) / 4;
        rd(6'h00, v); chk("R1 claim free", v, 0);
        rd(6'h00, v); chk("R2 claim held", v, 1);
        rd(6'h1C, v); chk("R3 status wait cmd", v, st(1, 1, 0));
        wr(6'h08, cmd);
        rd(6'h1C, v); chk("R4 state len", v, st(1, 2, 0));
        wr(6'h0C, 32'(len));
        rd(6'h1C, v); chk("R4 state data", v, st(1, 3, 0));
        for (int i = 0; i < need + extra; i++) wr(6'h10, exp_w[i]);
        wr(6'h18, 1);
        rd(6'h1C, v); chk("R4 running", v, st(1, 4, 0));
        chk("R4 rsp_cmd", rsp_cmd, cmd);
        chk("R4 rsp_len", 32'(rsp_len), 32'(len));
        drain("R6 words", need);
        respond(f, res);
        rd(6'h1C, v); chk("R7 result", v, st(1, 5, f ? 3 : 2));
        rd(6'h14, v); chk("R7 dout", v, res);
        wr(6'h18, 0);
        rd(6'h1C, v); chk("R8 released", v, 0);
        chk("R8 no words", 32'(rsp_valid), 0);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, cmd, cs;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        rd(6'h1C, v); chk("R3 reset status", v, 0);
        rd(6'h04, v); chk("R11 user free", v, 0);

        // R4 R6 R7 R8: sweep byte lengths with overfill
        for (int len = 1; len <= 24; len++) begin
            for (int i = 0; i < 64; i++) exp_w[i] = {16'(len), 16'(i)} ^ 32'h5A00_0000;
            run_txn(32'hC0DE_0000 + 32'(len), len, 2, len[0], ~32'(len));
        end

        // R9: writes while unclaimed are ignored
        wr(6'h08, 32'h1111_1111);
        wr(6'h0C, 8);
        wr(6'h10, 32'hDEAD_BEEF);
        wr(6'h10, 32'hDEAD_BEEF);
        wr(6'h18, 1);
        rd(6'h1C, v); chk("R9 status idle", v, 0);
        rd(6'h08, v); chk("R9 cmd untouched", v, 0);
        for (int i = 0; i < 64; i++) exp_w[i] = 32'h7700_0000 + 32'(i);
        run_txn(32'h0000_0099, 8, 0, 0, 32'h1234_5678);

        // R5: each misplaced write in each setup state
        for (int stage = 1; stage <= 3; stage++) begin
            for (int bad = 0; bad < 3; bad++) begin
                logic [5:0] ba;
                ba = (bad == 0) ? 6'h08 : (bad == 1) ? 6'h0C : 6'h10;
                if (bad == stage - 1) continue;
                if (stage == 3 && bad == 2) continue;
                rd(6'h00, v);
                if (stage >= 2) wr(6'h08, 32'h42);
                if (stage >= 3) wr(6'h0C, 4);
                wr(ba, 32'h5);
                rd(6'h1C, v); chk("R5 fault", v, st(1, 6, 0));
                wr(6'h18, 0);
                rd(6'h1C, v); chk("R5 fault cleared", v, 0);
            end
        end

        // R11: user register when claimed
        rd(6'h00, v);
        rd(6'h04, v); chk("R11 user held", v, UID);
        // R10: force release while responder is running
        wr(6'h08, 32'h77); wr(6'h0C, 4); wr(6'h10, 32'hABCD); wr(6'h18, 1);
        chk("R10 pending word", 32'(rsp_valid), 1);
        wr(6'h20, 1);
        rd(6'h1C, v); chk("R10 forced idle", v, 0);
        chk("R10 port empty", 32'(rsp_valid), 0);
        rd(6'h00, v); chk("R10 claim free again", v, 0);
        wr(6'h20, 1);

        // R6: signature-check transaction, 196 bytes
        cmd = 32'h5349_4756;
        for (int i = 1; i < 49; i++) exp_w[i] = 32'h0102_0304 * 32'(i) + 32'h00F0_0F00;
        cs = 0;
        for (int b = 0; b < 4; b++) cs = cs - 32'(cmd[8*b +: 8]);
        for (int i = 1; i < 49; i++)
            for (int b = 0; b < 4; b++) cs = cs - 32'(exp_w[i][8*b +: 8]);
        exp_w[0] = cs;
        run_txn(cmd, 196, 3, 0, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule